// File: doc/BRIEF.md
# Per-Channel Hit Charge and Time Calibrator

This block sits in a detector readout path and corrects raw hits one at a time. Each hit carries a channel number, a 10-bit raw charge code and a timestamp in picoseconds. The block subtracts the channel's pedestal from the charge and turns the net charge into a whole photoelectron count. It does this with a per-channel reciprocal gain and rounding to nearest. It then aligns the timestamp to a common reference by removing the channel's static offset. Last, it subtracts a time-walk term taken from a shared table indexed by the photoelectron count.

The calibration constants are written through a small write-only register port. A single enable bit gates the hit stream. Constants can only be changed while that bit is low, so a hit in flight never sees a half-updated calibration. With the block enabled, hits enter on every cycle and leave a fixed four cycles later.

Top module: `hit_calibrator`

## Requirements
- R1: After reset, out_valid is low, the enable bit is low, and every pedestal, gain, offset and walk entry is zero. Once the block is enabled with no constants written, a hit leaves with a count of 0 and its timestamp unchanged.
- R2: A hit taken in the cycle ending at clock edge k appears on the outputs after edge k+3, so the latency is 4 cycles. out_valid is high exactly for the hits taken. Hits on consecutive cycles leave on consecutive cycles with no gaps.
- R3: A hit is taken only when in_valid is high and the enable bit is 1. A hit offered while the block is disabled produces no output.
- R4: The net charge is the raw code minus the pedestal of the hit's channel. A raw code below the pedestal gives a count of 0.
- R5: The count is (net × gain + 8) >> 4. The gain is the channel's unsigned 8-bit reciprocal gain and the shift is 4, which gives round-half-up.
- R6: out_time = in_time − offset[ch] − walk[idx], taken modulo 2^24. Offsets and walk entries are signed 16-bit values and are sign-extended before the subtraction.
- R7: The walk index is the count when the count is below 63, and 63 otherwise. The table has 64 entries.
- R8: The register map is addr = region × 64 + index. Region 0 holds the pedestals (wdata[9:0], index = channel 0..31). Region 1 holds the gains (wdata[7:0]). Region 2 holds the offsets (wdata[15:0]). Region 3 holds the walk entries (wdata[15:0], index 0..63). Region 4, index 0, is the control word, whose bit 0 is the enable bit.
- R9: Writes to regions 0 to 3 take effect only while the enable bit is 0. While it is 1 they are ignored, but control writes always take effect.
- R10: out_ch returns the channel number of the hit being output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Hit present this cycle |
| in_ch | input | 5 | Hit channel |
| in_charge | input | 10 | Raw charge code |
| in_time | input | 24 | Raw timestamp, ps |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register address (region × 64 + index) |
| cfg_wdata | input | 16 | Register write data |
| out_valid | output | 1 | Corrected hit present |
| out_ch | output | 5 | Channel of the corrected hit |
| out_pe | output | 14 | Photoelectron count |
| out_time | output | 24 | Corrected timestamp, ps, modulo 2^24 |

## Verification
The case hardest to reach from the ports is a register write made while the block is enabled. Such a write must leave no trace, and a trace can only be seen through the count and time of a later hit. The bench writes a pedestal large enough that, had it landed, the same hit's count would fall to zero and its walk term would change. It then sends that hit and compares both fields against values worked out beforehand. Saturation of the walk index needs a high gain together with a large net charge, so both the directed hits and part of the random stream drive full-scale codes into the high-gain channels.

// File: rtl/hcal_pkg.sv
package hcal_pkg;

  // Register regions, selected by the upper three address bits.
  typedef enum logic [2:0] {
    RG_PED  = 3'd0,
    RG_GAIN = 3'd1,
    RG_OFF  = 3'd2,
    RG_WALK = 3'd3,
    RG_CTRL = 3'd4
  } cfg_region_e;

endpackage

// File: rtl/hcal_cfg_store.sv
module hcal_cfg_store
  import hcal_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int QW     = 10,
  parameter int GW     = 8,
  parameter int CW     = 16,
  parameter int WALK_N = 64,
  parameter int CFG_AW = 9,
  localparam int CHW   = $clog2(NCH),
  localparam int WIDX  = $clog2(WALK_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CW-1:0]     wdata,
  input  logic [CHW-1:0]    rd_ch,
  input  logic [WIDX-1:0]   rd_widx,
  output logic              cal_en,
  output logic [QW-1:0]     rd_ped,
  output logic [GW-1:0]     rd_gain,
  output logic [CW-1:0]     rd_off,
  output logic [CW-1:0]     rd_walk
);

  localparam int SLOT = CFG_AW - 3;

  logic [2:0]      region;
  logic [SLOT-1:0] slot_idx;
  logic            mem_wr_ok;   // memory write allowed this cycle
  logic            ctrl_hit;    // control word addressed

  logic [NCH-1:0][QW-1:0]    ped_q;
  logic [NCH-1:0][GW-1:0]    gain_q;
  logic [NCH-1:0][CW-1:0]    off_q;
  logic [WALK_N-1:0][CW-1:0] walk_q;

  assign region    = 3'(addr >> SLOT);
  assign slot_idx  = SLOT'(addr);
  assign mem_wr_ok = we && !cal_en;
  assign ctrl_hit  = we && (region == RG_CTRL) && (slot_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cal_en <= 1'b0;
    else if (ctrl_hit) cal_en <= wdata[0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ped_q[c]  <= '0;
        gain_q[c] <= '0;
        off_q[c]  <= '0;
      end else if (mem_wr_ok && slot_idx == SLOT'(c)) begin
        if (region == RG_PED)  ped_q[c]  <= QW'(wdata);
        if (region == RG_GAIN) gain_q[c] <= GW'(wdata);
        if (region == RG_OFF)  off_q[c]  <= wdata;
      end
    end
  end

  for (genvar w = 0; w < WALK_N; w++) begin : g_walk
    always_ff @(posedge clk) begin
      if (!rst_n)
        walk_q[w] <= '0;
      else if (mem_wr_ok && region == RG_WALK && slot_idx == SLOT'(w))
        walk_q[w] <= wdata;
    end
  end

  assign rd_ped  = ped_q[rd_ch];
  assign rd_gain = gain_q[rd_ch];
  assign rd_off  = off_q[rd_ch];
  assign rd_walk = walk_q[rd_widx];

  // R9: while enabled, a write outside the control region changes no constant
  assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && cal_en && region != RG_CTRL) |=>
      ($stable(ped_q) && $stable(gain_q) && $stable(off_q) && $stable(walk_q)));

  // R8: the control word lands in the enable bit
  assert_ctrl_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> (cal_en == $past(wdata[0])));

endmodule

// File: rtl/hcal_pe_stage.sv
module hcal_pe_stage #(
  parameter int QW    = 10,
  parameter int GW    = 8,
  parameter int SHIFT = 4,
  localparam int PEW  = QW + GW - SHIFT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_v,
  input  logic [QW-1:0]  charge,
  input  logic [QW-1:0]  ped,
  input  logic [GW-1:0]  gain,
  output logic           out_v,
  output logic [PEW-1:0] pe
);

  localparam int QGW  = QW + GW;
  localparam int HALF = 1 << (SHIFT - 1);

  // Pedestal subtraction with clamp, reciprocal-gain scaling, round half up.
  function automatic logic [PEW-1:0] charge_to_pe(input logic [QW-1:0] q,
                                                  input logic [QW-1:0] p,
                                                  input logic [GW-1:0] g);
    logic [QW:0]    diff;
    logic [QW-1:0]  net;
    logic [QGW-1:0] scaled;
    diff   = {1'b0, q} - {1'b0, p};
    net    = diff[QW] ? '0 : diff[QW-1:0];
    scaled = (QGW'(net) * QGW'(g) + QGW'(HALF)) >> SHIFT;
    return PEW'(scaled);
  endfunction

  logic [PEW-1:0] pe_next;
  assign pe_next = charge_to_pe(charge, ped, gain);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      pe    <= '0;
    end else begin
      out_v <= in_v;
      pe    <= pe_next;
    end
  end

  // R4: a charge below the pedestal gives zero photoelectrons
  assert_clamp_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && $past(charge < ped)) |-> (pe == '0));

  // R5: zero gain gives zero photoelectrons
  assert_zero_gain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && $past(gain == '0)) |-> (pe == '0));

endmodule

// File: rtl/hcal_time_stage.sv
module hcal_time_stage #(
  parameter int PEW    = 14,
  parameter int TW     = 24,
  parameter int CW     = 16,
  parameter int WALK_N = 64,
  localparam int WIDX  = $clog2(WALK_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_v,
  input  logic [PEW-1:0]  in_pe,
  input  logic [TW-1:0]   in_time,
  input  logic [CW-1:0]   in_off,
  output logic [WIDX-1:0] widx,
  input  logic [CW-1:0]   walk_val,
  output logic            out_v,
  output logic [PEW-1:0]  out_pe,
  output logic [TW-1:0]   out_time
);

  function automatic logic [WIDX-1:0] sat_index(input logic [PEW-1:0] p);
    if (p >= PEW'(WALK_N - 1)) return WIDX'(WALK_N - 1);
    return WIDX'(p);
  endfunction

  // Subtract a signed correction from a wrapping timestamp.
  function automatic logic [TW-1:0] minus_sext(input logic [TW-1:0] a,
                                               input logic [CW-1:0] b);
    return a - TW'($signed(b));
  endfunction

  logic           v3;
  logic [PEW-1:0] pe3;
  logic [TW-1:0]  t_aligned;
  logic [CW-1:0]  walk3;

  assign widx = sat_index(in_pe);

  // Stage 3: channel offset removal and walk-table read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v3        <= 1'b0;
      pe3       <= '0;
      t_aligned <= '0;
      walk3     <= '0;
    end else begin
      v3        <= in_v;
      pe3       <= in_pe;
      t_aligned <= minus_sext(in_time, in_off);
      walk3     <= walk_val;
    end
  end

  // Stage 4: walk correction
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_pe   <= '0;
      out_time <= '0;
    end else begin
      out_v    <= v3;
      out_pe   <= pe3;
      out_time <= minus_sext(t_aligned, walk3);
    end
  end

  // R7: the index follows the count until it saturates at the last entry
  assert_walk_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_v |-> ((widx == WIDX'(WALK_N - 1)) || (PEW'(widx) == in_pe)));

  assert_walk_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && in_pe >= PEW'(WALK_N)) |-> (widx == WIDX'(WALK_N - 1)));

endmodule

// File: rtl/hit_calibrator.sv
module hit_calibrator #(
  parameter int NCH    = 32,
  parameter int QW     = 10,
  parameter int GW     = 8,
  parameter int SHIFT  = 4,
  parameter int TW     = 24,
  parameter int CW     = 16,
  parameter int WALK_N = 64,
  parameter int CFG_AW = 9,
  localparam int CHW   = $clog2(NCH),
  localparam int PEW   = QW + GW - SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHW-1:0]    in_ch,
  input  logic [QW-1:0]     in_charge,
  input  logic [TW-1:0]     in_time,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CW-1:0]     cfg_wdata,
  output logic              out_valid,
  output logic [CHW-1:0]    out_ch,
  output logic [PEW-1:0]    out_pe,
  output logic [TW-1:0]     out_time
);

  localparam int WIDX = $clog2(WALK_N);

  logic            cal_en;
  logic            hit_take;   // hit accepted into stage 1
  logic [QW-1:0]   ped_rd;
  logic [GW-1:0]   gain_rd;
  logic [CW-1:0]   off_rd;
  logic [CW-1:0]   walk_rd;
  logic [WIDX-1:0] walk_idx;

  // Stage 1 registers
  logic           v1;
  logic [CHW-1:0] ch1;
  logic [QW-1:0]  q1;
  logic [TW-1:0]  t1;
  logic [QW-1:0]  ped1;
  logic [GW-1:0]  gain1;
  logic [CW-1:0]  off1;

  // Stage 2 side-band registers
  logic           v2;
  logic [PEW-1:0] pe2;
  logic [CHW-1:0] ch2, ch3;
  logic [TW-1:0]  t2;
  logic [CW-1:0]  off2;

  assign hit_take = in_valid && cal_en;

  hcal_cfg_store #(
    .NCH(NCH), .QW(QW), .GW(GW), .CW(CW), .WALK_N(WALK_N), .CFG_AW(CFG_AW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rd_ch(in_ch), .rd_widx(walk_idx), .cal_en(cal_en),
    .rd_ped(ped_rd), .rd_gain(gain_rd), .rd_off(off_rd), .rd_walk(walk_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; ch1 <= '0; q1 <= '0; t1 <= '0;
      ped1 <= '0; gain1 <= '0; off1 <= '0;
    end else begin
      v1 <= hit_take; ch1 <= in_ch; q1 <= in_charge; t1 <= in_time;
      ped1 <= ped_rd; gain1 <= gain_rd; off1 <= off_rd;
    end
  end

  hcal_pe_stage #(.QW(QW), .GW(GW), .SHIFT(SHIFT)) u_pe (
    .clk(clk), .rst_n(rst_n), .in_v(v1), .charge(q1), .ped(ped1), .gain(gain1),
    .out_v(v2), .pe(pe2)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch2 <= '0; t2 <= '0; off2 <= '0; ch3 <= '0; out_ch <= '0;
    end else begin
      ch2 <= ch1; t2 <= t1; off2 <= off1; ch3 <= ch2; out_ch <= ch3;
    end
  end

  hcal_time_stage #(.PEW(PEW), .TW(TW), .CW(CW), .WALK_N(WALK_N)) u_time (
    .clk(clk), .rst_n(rst_n), .in_v(v2), .in_pe(pe2), .in_time(t2),
    .in_off(off2), .widx(walk_idx), .walk_val(walk_rd),
    .out_v(out_valid), .out_pe(out_pe), .out_time(out_time)
  );

  // R2: every output hit was accepted exactly four edges earlier, and vice versa
  assert_latency_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(hit_take, 4));

  assert_latency_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_take |-> ##4 out_valid);

  // R3: stage 1 only fills from a hit offered while enabled
  assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> $past(in_valid && cal_en));

endmodule

// File: tb/hit_calibrator_tb_top.sv
module hit_calibrator_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  in_ch = '0;
  logic [9:0]  in_charge = '0;
  logic [23:0] in_time = '0;
  logic        cfg_we = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        out_valid;
  logic [4:0]  out_ch;
  logic [13:0] out_pe;
  logic [23:0] out_time;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  always #2 clk = ~clk;   // 250 MHz

  hit_calibrator dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
    .in_charge(in_charge), .in_time(in_time), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
    .out_ch(out_ch), .out_pe(out_pe), .out_time(out_time)
  );

  // ---------------- behavioural reference model ----------------
  int m_ped[32], m_gain[32], m_off[32], m_walk[64];
  bit m_en;
  bit d_v[4];
  int d_ch[4], d_pe[4], d_t[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0;
      for (int i = 0; i < 32; i++) begin m_ped[i] = 0; m_gain[i] = 0; m_off[i] = 0; end
      for (int i = 0; i < 64; i++) m_walk[i] = 0;
      for (int i = 0; i < 4; i++) begin d_v[i] = 0; d_ch[i] = 0; d_pe[i] = 0; d_t[i] = 0; end
    end else begin
      for (int i = 3; i > 0; i--) begin
        d_v[i] = d_v[i-1]; d_ch[i] = d_ch[i-1]; d_pe[i] = d_pe[i-1]; d_t[i] = d_t[i-1];
      end
      d_v[0] = in_valid && m_en;
      if (d_v[0]) begin
        int c, net, pe, ix, tt;
        c = int'(in_ch);
        net = int'(in_charge) - m_ped[c];
        if (net < 0) net = 0;
        pe = (net * m_gain[c] + 8) / 16;
        ix = (pe > 63) ? 63 : pe;
        tt = int'(in_time) - m_off[c] - m_walk[ix];
        d_ch[0] = c; d_pe[0] = pe; d_t[0] = tt & 32'h00FF_FFFF;
      end
      if (cfg_we) begin
        int rg, ix;
        rg = int'(cfg_addr) / 64;
        ix = int'(cfg_addr) % 64;
        if (rg == 4 && ix == 0) m_en = cfg_wdata[0];
        else if (!m_en) begin
          if (rg == 0 && ix < 32) m_ped[ix]  = int'(cfg_wdata) % 1024;
          if (rg == 1 && ix < 32) m_gain[ix] = int'(cfg_wdata) % 256;
          if (rg == 2 && ix < 32) m_off[ix]  = int'($signed(cfg_wdata));
          if (rg == 3)            m_walk[ix] = int'($signed(cfg_wdata));
        end
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (out_valid !== (rst_n && d_v[3])) begin
      failures++;
      $display("FAIL %s/R2 out_valid act=%0b exp=%0b", tag, out_valid, rst_n && d_v[3]);
    end
    if (rst_n && d_v[3] && out_valid) begin
      checks += 3;
      if (int'(out_ch) != d_ch[3]) begin
        failures++;
        $display("FAIL %s/R10 out_ch act=%0d exp=%0d", tag, out_ch, d_ch[3]);
      end
      if (int'(out_pe) != d_pe[3]) begin
        failures++;
        $display("FAIL %s/R5 out_pe act=%0d exp=%0d", tag, out_pe, d_pe[3]);
      end
      if (int'(out_time) != d_t[3]) begin
        failures++;
        $display("FAIL %s/R6 out_time act=%0d exp=%0d", tag, out_time, d_t[3]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 9'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic single_hit(input int c, input int q, input int t,
                            input int exp_pe, input int exp_t, input string rtag);
    @(negedge clk);
    in_valid = 1'b1; in_ch = 5'(c); in_charge = 10'(q); in_time = 24'(t);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (!out_valid || int'(out_pe) != exp_pe || int'(out_time) != exp_t) begin
      failures++;
      $display("FAIL %s directed v=%0b pe act=%0d exp=%0d time act=%0d exp=%0d",
               rtag, out_valid, out_pe, exp_pe, out_time, exp_t);
    end
  endtask

  function automatic bit [31:0] xs32(input bit [31:0] s);
    bit [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  // ---------------- main sequence ----------------
  initial begin
    bit [31:0] r;
    r = 32'h1234_5678;
    tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: offered while disabled after reset -> nothing comes out
    tag = "R3";
    @(negedge clk); in_valid = 1'b1; in_ch = 5'd7; in_charge = 10'd300;
    @(negedge clk); in_valid = 1'b0;
    repeat (6) @(negedge clk);

    // R1: zeroed constants leave the timestamp untouched, count 0
    cfg_write(256, 1);
    single_hit(5, 100, 5000, 0, 5000, "R1");

    // R8: load every table while disabled
    tag = "R8";
    cfg_write(256, 0);
    repeat (6) @(negedge clk);
    for (int c = 0; c < 32; c++) begin
      cfg_write(c, 40 + c * 5);
      cfg_write(64 + c, 4 + c * 8);
      cfg_write(128 + c, c * 300 - 4000);
    end
    for (int i = 0; i < 64; i++) cfg_write(192 + i, 1500 - i * 50);
    cfg_write(3, 0);          // ch3 pedestal 0
    cfg_write(64 + 3, 8);     // ch3 gain 8
    cfg_write(128 + 3, 0);    // ch3 offset 0
    cfg_write(256, 1);

    // R5: net 1, gain 8 -> (8+8)>>4 = 1; walk[1]=1450
    single_hit(3, 1, 20000, 1, 18550, "R5");
    // R7: ch31 net 828, gain 252 -> 13041, index saturates at 63 (walk -1650), offset 5300
    single_hit(31, 1023, 50000, 13041, 46350, "R7");
    // R6: 100 - 0 - 1500 wraps to 2^24 - 1400
    single_hit(3, 0, 100, 0, 16775816, "R6");
    // R9: pedestal write while enabled is dropped: net 100*8 -> 50, walk[50] = -1000
    cfg_write(3, 500);
    single_hit(3, 100, 20000, 50, 21000, "R9");

    // R2 R4 R5 R6 R7: full-rate stream, mostly back to back
    tag = "R2R4R7";
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      r = xs32(r);
      in_valid  = (r[2:0] != 3'd0);
      in_ch     = r[7:3];
      case (r[9:8])
        2'd0:    in_charge = 10'(r[15:10] % 40);
        2'd3:    in_charge = 10'd1023;
        default: in_charge = r[19:10];
      endcase
      in_time = (r[20]) ? 24'(r[31:21]) : {r[31:21], r[12:0]};
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (6) @(negedge clk);

    // R5: gain 7, net 1 -> (7+8)>>4 = 0, walk[0] = 1500
    cfg_write(256, 0);
    repeat (6) @(negedge clk);
    cfg_write(64 + 3, 7);
    cfg_write(3, 0);
    cfg_write(256, 1);
    single_hit(3, 1, 20000, 0, 18500, "R5");

    // R3: disabled again, hits are dropped
    tag = "R3";
    cfg_write(256, 0);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk); in_valid = 1'b1; in_ch = 5'(n); in_charge = 10'(n * 40);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (8) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule